// File: doc/BRIEF.md
# Mode-Partitioned Two-Thread Op Queue

This block is a shared FIFO holding operations from two hardware threads, meant to sit between a fetch/decode stage and an allocation stage. A run-time mode chooses how the storage is shared. With both threads active, each thread owns a fixed half of the entries. A thread that stops pushing or stops popping therefore cannot take space from the other. With one thread active, that thread gets every entry, and the idle thread looks permanently full and empty.

Each thread has its own push port, which reports full, and its own ready input, which reports empty. A single read port serves the threads. When both threads have data and are ready, the port alternates between them. When only one thread qualifies, that thread is served every cycle. Every entry leaving the block is tagged with the thread that wrote it. A mode change takes effect only while the whole queue is empty; otherwise it is refused and flagged.

Top module: `dual_thread_opq`

## Requirements
- R1: After reset the mode is dual (code 2'b00), both threads report empty and not full, `out_valid` is low and `mode_err` is low.
- R2: In dual mode each thread holds at most DEPTH/2 entries. Its full flag rises after DEPTH/2 accepted pushes, and a push while full is dropped.
- R3: Each thread's entries leave in the order they were pushed, and each carries `out_tid` equal to that thread's number (0 or 1).
- R4: When both threads are ready and non-empty, the read port alternates between them cycle by cycle. The first such grant after reset goes to thread 0.
- R5: When exactly one thread is ready and non-empty, that thread is served in every cycle.
- R6: In dual mode, a thread whose half is full and not drained does not stop the other thread from pushing and popping.
- R7: In single-thread mode (code 2'b01 = thread 0 only, 2'b10 = thread 1 only) the active thread holds DEPTH entries before its full flag rises.
- R8: In single-thread mode the inactive thread reports full and empty. Its pushes are dropped, and its ready input causes no output.
- R9: A mode request (`mode_wr` with code `mode_sel`) made while both threads are empty is applied on the next clock edge. Pushes made in that same cycle are dropped.
- R10: A mode request made while either thread holds data, or with code 2'b11, leaves the mode unchanged and raises `mode_err` for one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_wr | input | 1 | Mode change request strobe |
| mode_sel | input | 2 | Requested mode: 00 dual, 01 thread 0 alone, 10 thread 1 alone |
| cur_mode | output | 2 | Mode in force |
| mode_err | output | 1 | One-cycle pulse for a refused mode request |
| th0_push | input | 1 | Thread 0 push |
| th0_data | input | W | Thread 0 push data |
| th0_full | output | 1 | Thread 0 cannot accept |
| th0_rdy | input | 1 | Downstream accepts thread 0 entries |
| th0_empty | output | 1 | Thread 0 holds nothing |
| th1_push | input | 1 | Thread 1 push |
| th1_data | input | W | Thread 1 push data |
| th1_full | output | 1 | Thread 1 cannot accept |
| th1_rdy | input | 1 | Downstream accepts thread 1 entries |
| th1_empty | output | 1 | Thread 1 holds nothing |
| out_valid | output | 1 | An entry leaves at the next edge |
| out_tid | output | 1 | Thread of the leaving entry |
| out_data | output | W | Data of the leaving entry |

## Verification
A thread can be pushed and popped in the same cycle. The bench provokes this by holding thread 0's ready high while it streams pushes back-to-back. The occupancy must stay bounded, and the scoreboard must see every item come out once, in order.

The read arbitration can also coincide with one half standing full. Thread 1 is drained alternately against a full thread 0, and each cycle's tag is compared with the expected 0,1,0,1 pattern followed by a run of thread 0 grants.

// File: rtl/dual_thread_opq.sv
module dual_thread_opq #(
  parameter int DEPTH = 16,
  parameter int W     = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         mode_wr,
  input  logic [1:0]   mode_sel,
  output logic [1:0]   cur_mode,
  output logic         mode_err,
  input  logic         th0_push,
  input  logic [W-1:0] th0_data,
  output logic         th0_full,
  input  logic         th0_rdy,
  output logic         th0_empty,
  input  logic         th1_push,
  input  logic [W-1:0] th1_data,
  output logic         th1_full,
  input  logic         th1_rdy,
  output logic         th1_empty,
  output logic         out_valid,
  output logic         out_tid,
  output logic [W-1:0] out_data
);
  localparam int AW   = $clog2(DEPTH);
  localparam int HALF = DEPTH / 2;
  localparam logic [AW:0] CAP_H = AW'(0) + (AW+1)'(HALF);
  localparam logic [AW:0] CAP_F = (AW+1)'(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp0, wp1, rp0, rp1;
  logic [AW:0]   cnt0, cnt1;
  logic          last;

  wire dual = (cur_mode == 2'b00);
  wire act0 = (cur_mode != 2'b10);
  wire act1 = (cur_mode != 2'b01);

  wire [AW:0] cap = dual ? CAP_H : CAP_F;

  assign th0_empty = (cnt0 == '0);
  assign th1_empty = (cnt1 == '0);
  assign th0_full  = !act0 || (cnt0 == cap);
  assign th1_full  = !act1 || (cnt1 == cap);

  wire [AW-1:0] wa0 = dual ? {1'b0, wp0[AW-2:0]} : wp0;
  wire [AW-1:0] wa1 = dual ? {1'b1, wp1[AW-2:0]} : wp1;
  wire [AW-1:0] ra0 = dual ? {1'b0, rp0[AW-2:0]} : rp0;
  wire [AW-1:0] ra1 = dual ? {1'b1, rp1[AW-2:0]} : rp1;

  wire elig0 = th0_rdy && !th0_empty;
  wire elig1 = th1_rdy && !th1_empty;
  wire gnt1  = elig1 && (!elig0 || !last);
  wire gnt0  = elig0 && !gnt1;

  assign out_valid = elig0 || elig1;
  assign out_tid   = gnt1;
  assign out_data  = gnt1 ? mem[ra1] : mem[ra0];

  wire all_empty = th0_empty && th1_empty;
  wire mode_ok   = mode_wr && all_empty && (mode_sel != 2'b11);
  wire do_push0  = th0_push && !th0_full && !mode_ok;
  wire do_push1  = th1_push && !th1_full && !mode_ok;

  always_ff @(posedge clk) begin
    if (do_push0) mem[wa0] <= th0_data;
    if (do_push1) mem[wa1] <= th1_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_mode <= 2'b00;
      mode_err <= 1'b0;
      wp0 <= '0; wp1 <= '0; rp0 <= '0; rp1 <= '0;
      cnt0 <= '0; cnt1 <= '0;
      last <= 1'b1;
    end else begin
      mode_err <= mode_wr && !mode_ok;
      if (mode_ok) begin
        cur_mode <= mode_sel;
        wp0 <= '0; wp1 <= '0; rp0 <= '0; rp1 <= '0;
      end else begin
        if (do_push0) wp0 <= wp0 + 1'b1;
        if (do_push1) wp1 <= wp1 + 1'b1;
        if (gnt0)     rp0 <= rp0 + 1'b1;
        if (gnt1)     rp1 <= rp1 + 1'b1;
      end
      cnt0 <= cnt0 + (AW+1)'(do_push0) - (AW+1)'(gnt0);
      cnt1 <= cnt1 + (AW+1)'(do_push1) - (AW+1)'(gnt1);
      if (out_valid) last <= gnt1;
    end
  end

  // R2
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dual |-> (cnt0 <= CAP_H) && (cnt1 <= CAP_H));

  // R4
  alternate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (elig0 && elig1 && $past(elig0 && elig1)) |-> (out_tid != $past(out_tid)));

  // R8
  idle_thread_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_mode == 2'b01) |-> (th1_full && th1_empty && !(out_valid && out_tid)));

  // R9
  mode_apply_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_mode != $past(cur_mode)) |-> $past(mode_wr && th0_empty && th1_empty));

  // R10
  mode_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_err |-> (cur_mode == $past(cur_mode)));
endmodule

// File: tb/dual_thread_opq_tb.sv
module dual_thread_opq_tb;
  localparam int DEPTH = 16;
  localparam int W     = 8;

  logic clk = 0, rst_n = 0;
  logic mode_wr = 0;
  logic [1:0] mode_sel = 0, cur_mode;
  logic mode_err;
  logic th0_push = 0, th1_push = 0, th0_rdy = 0, th1_rdy = 0;
  logic [W-1:0] th0_data = 0, th1_data = 0, out_data;
  logic th0_full, th1_full, th0_empty, th1_empty, out_valid, out_tid;

  int errors = 0, checks = 0;
  logic [W-1:0] q0[$], q1[$];
  bit done = 0;

  always #10 clk = ~clk;

  dual_thread_opq #(.DEPTH(DEPTH), .W(W)) u_dut (
    .clk, .rst_n, .mode_wr, .mode_sel, .cur_mode, .mode_err,
    .th0_push, .th0_data, .th0_full, .th0_rdy, .th0_empty,
    .th1_push, .th1_data, .th1_full, .th1_rdy, .th1_empty,
    .out_valid, .out_tid, .out_data);

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic push(bit t, logic [W-1:0] d);
    if (!t) begin
      th0_push = 1; th0_data = d;
      if (!th0_full) q0.push_back(d);
    end else begin
      th1_push = 1; th1_data = d;
      if (!th1_full) q1.push_back(d);
    end
    step();
    th0_push = 0; th1_push = 0;
  endtask

  task automatic drain();
    th0_rdy = 1; th1_rdy = 1;
    for (int i = 0; i < 100 && !(th0_empty && th1_empty); i++) step();
    th0_rdy = 0; th1_rdy = 0;
  endtask

  task automatic set_mode(logic [1:0] m);
    mode_wr = 1; mode_sel = m;
    step();
    mode_wr = 0;
  endtask

  // scoreboard monitor (R3)
  always @(negedge clk) begin
    if (rst_n && out_valid && (out_tid ? th1_rdy : th0_rdy)) begin
      if (!out_tid) begin
        if (q0.size() == 0) chk(0, "R3 unexpected t0 entry", out_data, -1);
        else begin
          automatic logic [W-1:0] e = q0.pop_front();
          chk(out_data == e, "R3 t0 data", out_data, e);
        end
      end else begin
        if (q1.size() == 0) chk(0, "R8/R3 unexpected t1 entry", out_data, -1);
        else begin
          automatic logic [W-1:0] e = q1.pop_front();
          chk(out_data == e, "R3 t1 data", out_data, e);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      chk(0, "watchdog", 0, 1);
      report();
    end
  end

  initial begin
    repeat (3) step();
    rst_n = 1;
    step();
    // R1
    chk(cur_mode == 2'b00 && th0_empty && th1_empty && !th0_full && !th1_full
        && !out_valid && !mode_err, "R1 reset state", cur_mode, 0);

    // R2: fill thread 0 half
    for (int i = 0; i < DEPTH/2 - 1; i++) push(0, 8'h10 + 8'(i));
    chk(!th0_full, "R2 not full one short", th0_full, 0);
    push(0, 8'h17);
    chk(th0_full, "R2 full at DEPTH/2", th0_full, 1);
    push(0, 8'hEE);
    chk(q0.size() == DEPTH/2, "R2 overflow dropped", q0.size(), DEPTH/2);

    // R6: thread 1 proceeds while thread 0 is stuck full
    for (int i = 0; i < 3; i++) push(1, 8'h80 + 8'(i));
    chk(!th1_full && !th1_empty, "R6 t1 accepts beside full t0", th1_full, 0);
    th1_rdy = 1;
    @(negedge clk);
    chk(out_valid && out_tid, "R6 t1 served while t0 stalled", out_tid, 1);
    step();
    th1_rdy = 0;
    push(1, 8'h83);

    // R4 / R5: both ready; expect 0,1,0,1,0,1 then 0 x5
    th0_rdy = 1; th1_rdy = 1;
    for (int i = 0; i < 11; i++) begin
      @(negedge clk);
      if (i < 6) chk(out_valid && out_tid == 1'(i % 2), "R4 alternation", out_tid, i % 2);
      else chk(out_valid && out_tid == 1'b0, "R5 sole thread every cycle", out_tid, 0);
      @(posedge clk); #1;
    end
    th0_rdy = 0; th1_rdy = 0;
    chk(th0_empty && th1_empty, "R5 both drained", th0_empty, 1);

    // R10: refused mode change
    push(0, 8'h33);
    set_mode(2'b01);
    chk(mode_err && cur_mode == 2'b00, "R10 refused while busy", cur_mode, 0);
    drain();
    chk(!mode_err, "R10 error is a pulse", mode_err, 0);
    set_mode(2'b11);
    chk(mode_err && cur_mode == 2'b00, "R10 code 11 refused", cur_mode, 0);

    // R9 / R7 / R8: single thread 0
    set_mode(2'b01);
    chk(cur_mode == 2'b01 && !mode_err, "R9 mode applied", cur_mode, 1);
    for (int i = 0; i < DEPTH - 1; i++) push(0, 8'h40 + 8'(i));
    chk(!th0_full, "R7 room for full depth", th0_full, 0);
    push(0, 8'h4F);
    chk(th0_full, "R7 full at DEPTH", th0_full, 1);
    chk(th1_full && th1_empty, "R8 idle thread flags", th1_full, 1);
    push(1, 8'hAA);
    chk(th1_empty && q1.size() == 0, "R8 idle push dropped", th1_empty, 1);
    th1_rdy = 1;
    @(negedge clk);
    chk(out_valid == 1'b0, "R8 idle ready gives no output", out_valid, 0);
    step();
    drain();
    chk(q0.size() == 0, "R7 all sixteen delivered", q0.size(), 0);

    // single thread 1
    set_mode(2'b10);
    chk(cur_mode == 2'b10 && th0_full && th0_empty, "R8 thread 1 alone", cur_mode, 2);
    for (int i = 0; i < 10; i++) push(1, 8'h60 + 8'(i));
    chk(!th1_full, "R7 thread 1 beyond half", th1_full, 0);
    drain();

    // R9: push in the cycle of an accepted change is dropped
    th1_push = 1; th1_data = 8'h99;
    set_mode(2'b00);
    th1_push = 0;
    chk(cur_mode == 2'b00 && th1_empty, "R9 same-cycle push dropped", th1_empty, 1);

    // concurrent push and pop on thread 0
    th0_rdy = 1;
    for (int i = 0; i < 12; i++) push(0, 8'hC0 + 8'(i));
    th0_rdy = 0;
    chk(!th0_full, "R2 streaming never fills", th0_full, 0);
    drain();
    chk(q0.size() == 0 && q1.size() == 0, "R3 scoreboard empty", q0.size() + q1.size(), 0);

    done = 1;
    report();
  end
endmodule